// File: doc/BRIEF.md
# Fast Gate-A20 Command Decoder

This block watches host writes to a keyboard-controller-style mailbox and drives the gate-A20 line directly in hardware. Firmware takes no part in it. A host first writes the set-gate command byte to the command port of the decoded channel. The next data-port write on that channel then supplies the new gate level in one bit of its byte. The level is latched on the clock edge that samples that data write. No processor interrupt has to be serviced first.

The decoder works only while the fast-gate enable is set. While the enable is clear, the pin follows a general-purpose level driven by firmware through the port logic. The pin is driven only when its direction control selects output. The gate level can be read back through a status output while the pin is an output. The bus protocol front end is outside this block. So are the firmware mailbox path and every other keyboard-controller command.

Top module: `a20_fastgate`

## Requirements
- R1: Reset sets the gate level to 1 and clears the armed state. A data write that follows reset with no new command leaves the level at 1.
- R2: A command-port write (`hst_cmd_i`=1) of byte 0xD1 arms the decoder. The next data-port write (`hst_cmd_i`=0) copies bit 1 of its byte into the gate level. The other seven bits have no effect.
- R3: Writes whose channel index is not 1 are ignored. They change neither the armed state nor the gate level.
- R4: A command-port write of any byte other than 0xD1 disarms the decoder. A following data write then leaves the level unchanged. A second 0xD1 while armed keeps the decoder armed.
- R5: A data write that does not follow an armed 0xD1 leaves the gate level unchanged.
- R6: A data write that loads the level also disarms the decoder. The next level change needs another 0xD1.
- R7: While `fast_en_i` is 0, writes are not decoded and the armed state is cleared, including on the edge where the enable drops together with a write. The pin follows `gp_level_i`. The latched level is kept and reappears when the enable returns to 1.
- R8: `a20_oe_o` equals `pin_dir_i`. `a20_stat_o` equals the pin value while `pin_dir_i` is 1 and is 0 while it is 0.
- R9: The level changes on the same edge that samples the qualifying data write. Writes on consecutive cycles are each decoded without a gap.
- R10: While `fast_en_i` is 1, the pin value equals the latched gate level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_i | input | 1 | Host write strobe, one cycle per write |
| hst_chan_i | input | 2 | Host mailbox channel index of the write |
| hst_cmd_i | input | 1 | 1 = command-port write, 0 = data-port write |
| hst_data_i | input | 8 | Host write data byte |
| fast_en_i | input | 1 | Fast-gate enable |
| pin_dir_i | input | 1 | Pin direction, 1 = output |
| gp_level_i | input | 1 | Firmware level used while the fast gate is disabled |
| a20_pin_o | output | 1 | Gate-A20 pin value |
| a20_oe_o | output | 1 | Pin output enable |
| a20_stat_o | output | 1 | Status copy of the pin value |

## Verification
Two functions can fall in the same cycle: a data write the decoder is armed to accept, and the fast-gate enable being cleared. The bench provokes this by dropping `fast_en_i` at the same falling edge that presents an armed data write. It then re-enables the gate and sends a further data write with no new command. It judges the result through the restored pin level, which must still be the old level, and through the fact that the second data write is also ignored. Back-to-back command and data writes on consecutive cycles check the same-edge load without gaps.

// File: rtl/a20_fastgate_pkg.sv
package a20_fastgate_pkg;

  // Decoded host write events for one cycle
  typedef struct packed {
    logic cmd_hit;   // command port, set-gate code
    logic cmd_miss;  // command port, any other code
    logic data_ev;   // data port write
  } wr_evt_t;

  function automatic logic code_match(input logic [7:0] b, input logic [7:0] code);
    return (b == code);
  endfunction

  function automatic logic pick_level(input logic [7:0] b, input int unsigned idx);
    return b[idx];
  endfunction

  function automatic logic stat_view(input logic dir_out, input logic pin);
    return dir_out & pin;
  endfunction

endpackage

// File: rtl/a20_wr_classify.sv
module a20_wr_classify
  import a20_fastgate_pkg::*;
#(
  parameter int DW = 8,
  parameter int CHW = 2,
  parameter int GATE_CH = 1,
  parameter logic [DW-1:0] GATE_CMD = 8'hD1
) (
  input  logic           wr_stb,
  input  logic [CHW-1:0] wr_chan,
  input  logic           cmd_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           fast_en,
  output wr_evt_t        evt
);
  localparam logic [CHW-1:0] CH_ID = CHW'(GATE_CH);

  logic ours;
  logic is_code;

  always_comb begin
    ours    = wr_stb && fast_en && (wr_chan == CH_ID);
    is_code = code_match(wr_data, GATE_CMD);
    evt.cmd_hit  = ours && cmd_sel && is_code;
    evt.cmd_miss = ours && cmd_sel && !is_code;
    evt.data_ev  = ours && !cmd_sel;
  end
endmodule

// File: rtl/a20_arm_seq.sv
module a20_arm_seq
  import a20_fastgate_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fast_en,
  input  wr_evt_t evt,
  output logic    armed_q,
  output logic    load_ev
);
  logic armed_n;

  always_comb begin
    armed_n = armed_q;
    if (!fast_en)                       armed_n = 1'b0;
    else if (evt.cmd_hit)               armed_n = 1'b1;
    else if (evt.cmd_miss || evt.data_ev) armed_n = 1'b0;
    load_ev = evt.data_ev && armed_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_n;
  end
endmodule

// File: rtl/a20_gate_latch.sv
module a20_gate_latch
  import a20_fastgate_pkg::*;
#(
  parameter int DW = 8,
  parameter int GATE_BIT = 1,
  parameter logic RST_LVL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic [DW-1:0] wr_data,
  output logic          lvl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       lvl_q <= RST_LVL;
    else if (load_ev) lvl_q <= pick_level(wr_data, GATE_BIT);
  end
endmodule

// File: rtl/a20_pin_mux.sv
module a20_pin_mux
  import a20_fastgate_pkg::*;
(
  input  logic fast_en,
  input  logic dir_out,
  input  logic lvl,
  input  logic gp_level,
  output logic pin,
  output logic oe,
  output logic stat
);
  always_comb begin
    pin  = fast_en ? lvl : gp_level;
    oe   = dir_out;
    stat = stat_view(dir_out, pin);
  end
endmodule

// File: rtl/a20_fastgate.sv
module a20_fastgate
  import a20_fastgate_pkg::*;
#(
  parameter int DW = 8,
  parameter int CHW = 2,
  parameter int GATE_CH = 1,
  parameter logic [DW-1:0] GATE_CMD = 8'hD1,
  parameter int GATE_BIT = 1,
  parameter logic RST_LVL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hst_wr_i,
  input  logic [CHW-1:0] hst_chan_i,
  input  logic           hst_cmd_i,
  input  logic [DW-1:0]  hst_data_i,
  input  logic           fast_en_i,
  input  logic           pin_dir_i,
  input  logic           gp_level_i,
  output logic           a20_pin_o,
  output logic           a20_oe_o,
  output logic           a20_stat_o
);
  wr_evt_t evt;
  logic    armed_q;
  logic    load_ev;
  logic    lvl_q;

  a20_wr_classify #(
    .DW(DW), .CHW(CHW), .GATE_CH(GATE_CH), .GATE_CMD(GATE_CMD)
  ) u_classify (
    .wr_stb(hst_wr_i), .wr_chan(hst_chan_i), .cmd_sel(hst_cmd_i),
    .wr_data(hst_data_i), .fast_en(fast_en_i), .evt(evt)
  );

  a20_arm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fast_en(fast_en_i), .evt(evt),
    .armed_q(armed_q), .load_ev(load_ev)
  );

  a20_gate_latch #(
    .DW(DW), .GATE_BIT(GATE_BIT), .RST_LVL(RST_LVL)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .load_ev(load_ev),
    .wr_data(hst_data_i), .lvl_q(lvl_q)
  );

  a20_pin_mux u_mux (
    .fast_en(fast_en_i), .dir_out(pin_dir_i), .lvl(lvl_q),
    .gp_level(gp_level_i), .pin(a20_pin_o), .oe(a20_oe_o), .stat(a20_stat_o)
  );
endmodule

// File: rtl/a20_fastgate_sva.sv
module a20_fastgate_sva #(
  parameter int DW = 8,
  parameter int CHW = 2,
  parameter int GATE_CH = 1,
  parameter logic [DW-1:0] GATE_CMD = 8'hD1,
  parameter int GATE_BIT = 1,
  parameter logic RST_LVL = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hst_wr_i,
  input logic [CHW-1:0] hst_chan_i,
  input logic           hst_cmd_i,
  input logic [DW-1:0]  hst_data_i,
  input logic           fast_en_i,
  input logic           pin_dir_i,
  input logic           armed_q,
  input logic           load_ev,
  input logic           lvl_q,
  input logic           a20_pin_o,
  input logic           a20_stat_o
);
  localparam logic [CHW-1:0] CH_ID = CHW'(GATE_CH);

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  // R1: the edge after a reset cycle shows the reset level, disarmed
  always @(posedge clk) begin
    if (was_rst === 1'b1 && rst_n) begin
      p_reset_level_r1: assert (lvl_q == RST_LVL && !armed_q)
        else $error("reset state wrong");
    end
  end

  p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en_i && hst_wr_i && hst_cmd_i && hst_chan_i == CH_ID && hst_data_i == GATE_CMD)
    |=> armed_q);

  p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (lvl_q == $past(hst_data_i[GATE_BIT])));

  p_foreign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en_i && hst_wr_i && hst_chan_i != CH_ID) |=> ($stable(armed_q) && $stable(lvl_q)));

  p_other_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr_i && hst_cmd_i && hst_chan_i == CH_ID && hst_data_i != GATE_CMD) |=> !armed_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(lvl_q));

  p_consume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !armed_q);

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en_i |=> !armed_q);

  p_stat_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_dir_i |-> !a20_stat_o);

  p_pin_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_en_i && pin_dir_i) |-> (a20_pin_o == lvl_q && a20_stat_o == lvl_q));
endmodule

bind a20_fastgate a20_fastgate_sva #(
  .DW(DW), .CHW(CHW), .GATE_CH(GATE_CH), .GATE_CMD(GATE_CMD),
  .GATE_BIT(GATE_BIT), .RST_LVL(RST_LVL)
) u_sva (
  .clk(clk), .rst_n(rst_n), .hst_wr_i(hst_wr_i), .hst_chan_i(hst_chan_i),
  .hst_cmd_i(hst_cmd_i), .hst_data_i(hst_data_i), .fast_en_i(fast_en_i),
  .pin_dir_i(pin_dir_i), .armed_q(armed_q), .load_ev(load_ev), .lvl_q(lvl_q),
  .a20_pin_o(a20_pin_o), .a20_stat_o(a20_stat_o)
);

// File: tb/a20_fastgate_tb_top.sv
module a20_fastgate_tb_top;
  localparam int CLK_P = 10;

  typedef struct {
    logic  pin;
    logic  oe;
    logic  stat;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_wr_i = 1'b0;
  logic [1:0] hst_chan_i = 2'd1;
  logic       hst_cmd_i = 1'b0;
  logic [7:0] hst_data_i = 8'h00;
  logic       fast_en_i = 1'b1;
  logic       pin_dir_i = 1'b1;
  logic       gp_level_i = 1'b0;
  logic       a20_pin_o, a20_oe_o, a20_stat_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t sbq[$];

  // reference model state
  logic m_lvl = 1'b1;
  logic m_armed = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  a20_fastgate dut_i (
    .clk(clk), .rst_n(rst_n), .hst_wr_i(hst_wr_i), .hst_chan_i(hst_chan_i),
    .hst_cmd_i(hst_cmd_i), .hst_data_i(hst_data_i), .fast_en_i(fast_en_i),
    .pin_dir_i(pin_dir_i), .gp_level_i(gp_level_i),
    .a20_pin_o(a20_pin_o), .a20_oe_o(a20_oe_o), .a20_stat_o(a20_stat_o)
  );

  task automatic push_exp(input string tag);
    exp_t e;
    e.pin  = fast_en_i ? m_lvl : gp_level_i;
    e.oe   = pin_dir_i;
    e.stat = pin_dir_i ? e.pin : 1'b0;
    e.tag  = tag;
    sbq.push_back(e);
  endtask

  // one cycle of stimulus, then the model advances and an expectation is queued
  task automatic step(input logic en, input logic dir, input logic gp, input logic stb,
                      input logic [1:0] ch, input logic cmd, input logic [7:0] d,
                      input string tag);
    @(negedge clk);
    fast_en_i = en; pin_dir_i = dir; gp_level_i = gp;
    hst_wr_i = stb; hst_chan_i = ch; hst_cmd_i = cmd; hst_data_i = d;
    @(posedge clk);
    if (!en) m_armed = 1'b0;
    else if (stb && ch == 2'd1) begin
      if (cmd) m_armed = (d == 8'hD1);
      else if (m_armed) begin
        m_lvl = d[1];
        m_armed = 1'b0;
      end
    end
    push_exp(tag);
  endtask

  task automatic wr(input logic cmd, input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd1, cmd, d, tag);
  endtask

  task automatic idle(input string tag);
    step(fast_en_i, pin_dir_i, gp_level_i, 1'b0, 2'd1, 1'b0, 8'h00, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; hst_wr_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_lvl = 1'b1; m_armed = 1'b0;
    @(posedge clk);
    push_exp(tag);
  endtask

  // monitor: compares the queued expectations a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (a20_pin_o !== e.pin || a20_oe_o !== e.oe || a20_stat_o !== e.stat) begin
          fails++;
          $display("FAIL %s: pin/oe/stat actual %b%b%b expected %b%b%b",
                   e.tag, a20_pin_o, a20_oe_o, a20_stat_o, e.pin, e.oe, e.stat);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset level");
    wr(1'b0, 8'h00, "R1 data after reset ignored");
    wr(1'b0, 8'h00, "R5 unarmed data ignored");
    wr(1'b1, 8'hD1, "R2 arm");
    wr(1'b0, 8'h00, "R2 load 0");
    wr(1'b0, 8'h02, "R6 second data ignored");
    wr(1'b1, 8'hD1, "R2 arm");
    wr(1'b0, 8'hFD, "R2 only bit 1 used");
    wr(1'b1, 8'hD1, "R2 arm");
    wr(1'b0, 8'h02, "R2 load 1");
    wr(1'b1, 8'hD1, "R3 arm");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0, 8'h00, "R3 foreign data ignored");
    step(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 8'h60, "R3 foreign command ignored");
    wr(1'b0, 8'h00, "R3 armed kept, load 0");
    wr(1'b1, 8'hD1, "R4 arm");
    wr(1'b1, 8'h60, "R4 other command");
    wr(1'b0, 8'h02, "R4 data after disarm ignored");
    wr(1'b1, 8'hD1, "R4 arm");
    wr(1'b1, 8'hD1, "R4 re-arm");
    wr(1'b0, 8'h02, "R4 load after double code");
    idle("R9 idle");
    step(1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 8'h00, "R7 pin follows gp 0");
    step(1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 1'b1, 8'hD1, "R7 code not decoded");
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 8'h00, "R7 data not decoded");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 8'h00, "R7 level restored");
    wr(1'b0, 8'h00, "R7 no arm left over");
    wr(1'b1, 8'hD1, "R7 arm before drop");
    step(1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 8'h00, "R7 enable drop with data");
    step(1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 8'h00, "R7 level kept after drop");
    wr(1'b0, 8'h00, "R7 disarmed by drop");
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 8'h00, "R8 input dir stat 0");
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 8'h00, "R8 stat shows gp pin");
    idle("R10 idle");
    wr(1'b1, 8'hD1, "R9 b2b arm");
    wr(1'b0, 8'h00, "R9 b2b load 0");
    wr(1'b1, 8'hD1, "R9 b2b arm");
    wr(1'b0, 8'h02, "R9 b2b load 1");
    wr(1'b1, 8'hD1, "R9 b2b arm");
    wr(1'b0, 8'h00, "R10 pin equals level 0");
    wr(1'b1, 8'hD1, "R1 arm before reset");
    do_reset("R1 reset mid run");
    wr(1'b0, 8'h00, "R1 reset cleared arm");
    idle("R1 final idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule